// File: doc/BRIEF.md
# Daisy-Chained DAC Serial Loader

This block loads one 12-bit setting into a chain of three octal DAC chips. The three chips share one serial data line, one serial clock and one active-low chip select. A request names a global channel index from 0 to 23 and either a value or a power-down. The block builds one 32-bit command frame for the chip that owns the channel and a no-operation frame for each of the other chips. It shifts all three frames out in a single chip-select window, so every chip in the chain latches its own frame at the same moment.

Each serial clock phase is stretched by a programmable divider. While a transaction runs, the block reports busy. On completion it pulses done and records the setting in a per-channel readback file. A request whose value or index is out of range gives a one-cycle reject pulse and causes no serial activity.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, `dac_cs_n`, `dac_sclk` and `dac_sdi` are all high, and `busy`, `done` and `reject` are low. Whenever the block is idle, all three serial lines stay high.
- R2: Each frame is 32 bits long and goes out most significant bit first. Bit 31:28 hold the command, bit 27:20 are zero, bit 19:16 hold the channel (index mod 8), bit 15:4 hold the value and bit 3:0 are zero. The receiving chips sample `dac_sdi` on each rising edge of `dac_sclk` while `dac_cs_n` is low.
- R3: The command code is 4'h3 for a write and 4'h4 for a power-down, and a power-down frame carries a zero value field. A pass-through frame is 32'hF000_0000.
- R4: A transaction gives exactly 96 rising edges of `dac_sclk` in one chip-select window. The first 2 − (index div 8) frames sent are pass-through frames, then comes the target frame, then pass-through frames for the rest of the chain.
- R5: `dac_sdi` changes only while `dac_sclk` is low. Every line phase lasts max(`phase_div`,1) clocks, with the divider value captured when the request is accepted. `busy` stays high for exactly 292 × max(`phase_div`,1) cycles.
- R6: `dac_cs_n` falls while `dac_sclk` and `dac_sdi` are high. `dac_sclk` then falls before the first bit. `dac_sclk` is low when `dac_cs_n` rises, and all lines return high one phase later.
- R7: A write value above 4095, or an index above 23, is refused. The block gives a one-cycle `reject` pulse the cycle after the request, `dac_cs_n` does not fall, and the stored readback is unchanged. `reject` and `done` are never high together.
- R8: After a write, `rd_data` for that index reads {1'b0, value} one cycle after `rd_index` is applied. An index that has never been written, or that is out of range, reads 0.
- R9: A power-down request ignores `req_value`, even a value above 4095. It is accepted, and its readback becomes 13'h1000 (bit 12 is the power-down marker, value bits zero).
- R10: A request that arrives while `busy` is high is ignored: it causes no reject, no extra chip-select window and no readback change.
- R11: `done` is high for exactly one cycle, in the first cycle where `busy` is low again and the serial lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_pdown | input | 1 | 1 = power-down request, 0 = write request |
| req_index | input | 5 | Global DAC channel index 0..23 |
| req_value | input | 16 | Requested setting; legal range 0..4095 |
| phase_div | input | 8 | System clocks per serial line phase (0 acts as 1) |
| rd_index | input | 5 | Readback index |
| rd_data | output | 13 | Readback: bit 12 power-down marker, bit 11:0 value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle pulse for a refused request |
| dac_sdi | output | 1 | Serial data to the chain |
| dac_sclk | output | 1 | Serial clock to the chain |
| dac_cs_n | output | 1 | Shared active-low chip select |

## Verification
The hardest situation to reach from the ports is a second request that lands in the middle of a live transaction. The block must swallow it without a reject, without a second window and without a readback write. The stimulus raises a request for a fresh index in the first cycle where busy is high and then reads that index back as zero. A second hard case is the frame order for each chip position. Table vectors cover the lowest and highest channel of each chip, and every rising serial clock edge is captured into a 96-bit word that is compared whole against the expected chain.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int FRAME_W = 32;
  localparam int VAL_W   = 12;
  localparam int MAX_VAL = (1 << VAL_W) - 1;

  typedef enum logic [3:0] {
    CMD_WRITE = 4'h3,
    CMD_PDOWN = 4'h4,
    CMD_NOP   = 4'hF
  } dac_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_DROP,
    ST_CLK_DROP,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_CS_RISE
  } ser_state_e;

  function automatic logic [FRAME_W-1:0] make_frame(dac_cmd_e cmd, logic [3:0] ch,
                                                    logic [VAL_W-1:0] val);
    return {cmd, 8'h00, ch, val, 4'h0};
  endfunction
endpackage

// File: rtl/dacw_chain_builder.sv
module dacw_chain_builder
  import dacw_pkg::*;
#(
  parameter int NUM_CHIPS   = 3,
  parameter int CH_PER_CHIP = 8,
  localparam int IDX_W      = $clog2(NUM_CHIPS * CH_PER_CHIP),
  localparam int CHAIN_W    = NUM_CHIPS * FRAME_W
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [VAL_W-1:0]   val,
  input  logic               pdown,
  output logic [CHAIN_W-1:0] chain
);
  logic [IDX_W-1:0]   chip_sel;
  logic [IDX_W-1:0]   chain_pos;
  logic [3:0]         chan;
  logic [FRAME_W-1:0] target;

  // chips further down the chain are reached first, so position counts backwards
  assign chip_sel  = idx / IDX_W'(CH_PER_CHIP);
  assign chain_pos = IDX_W'(NUM_CHIPS - 1) - chip_sel;
  assign chan      = 4'(idx % IDX_W'(CH_PER_CHIP));
  assign target    = pdown ? make_frame(CMD_PDOWN, chan, '0)
                           : make_frame(CMD_WRITE, chan, val);

  for (genvar j = 0; j < NUM_CHIPS; j++) begin : g_slot
    assign chain[CHAIN_W-1-FRAME_W*j -: FRAME_W] =
      (chain_pos == IDX_W'(j)) ? target : make_frame(CMD_NOP, 4'h0, '0);
  end
endmodule

// File: rtl/dacw_phase_timer.sv
module dacw_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             phase_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_eff;

  assign lim_eff   = (limit == '0) ? DIV_W'(1) : limit;
  assign phase_end = run && (cnt == lim_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || phase_end) cnt <= '0;
    else                          cnt <= cnt + DIV_W'(1);
  end

  p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < lim_eff));
endmodule

// File: rtl/dacw_serializer.sv
module dacw_serializer
  import dacw_pkg::*;
#(
  parameter int CHAIN_W = 96,
  localparam int CNT_W  = $clog2(CHAIN_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CHAIN_W-1:0] chain,
  input  logic               phase_end,
  output logic               busy,
  output logic               sdi,
  output logic               sclk,
  output logic               cs_n,
  output logic               finished
);
  ser_state_e         st;
  logic [CHAIN_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      sdi      <= 1'b1;
      sclk     <= 1'b1;
      cs_n     <= 1'b1;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          shreg   <= chain;
          bit_cnt <= '0;
          cs_n    <= 1'b0;
          st      <= ST_CS_DROP;
        end
        ST_CS_DROP: if (phase_end) begin
          sclk <= 1'b0;
          st   <= ST_CLK_DROP;
        end
        ST_CLK_DROP: if (phase_end) begin
          sdi <= shreg[CHAIN_W-1];
          st  <= ST_SETUP;
        end
        ST_SETUP: if (phase_end) begin
          sclk <= 1'b1;
          st   <= ST_HIGH;
        end
        ST_HIGH: if (phase_end) begin
          sclk <= 1'b0;
          st   <= ST_LOW;
        end
        ST_LOW: if (phase_end) begin
          if (bit_cnt == CNT_W'(CHAIN_W - 1)) begin
            st <= ST_TAIL;
          end else begin
            shreg   <= shreg << 1;
            sdi     <= shreg[CHAIN_W-2];
            bit_cnt <= bit_cnt + CNT_W'(1);
            st      <= ST_SETUP;
          end
        end
        ST_TAIL: if (phase_end) begin
          cs_n <= 1'b1;
          st   <= ST_CS_RISE;
        end
        ST_CS_RISE: if (phase_end) begin
          sdi      <= 1'b1;
          sclk     <= 1'b1;
          finished <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (cs_n && sclk && sdi));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk) |-> $stable(sdi));
  p_cs_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk && sdi));
  p_cs_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !sclk);
  p_bit_count_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TAIL) |-> (bit_cnt == CNT_W'(CHAIN_W - 1)));
endmodule

// File: rtl/dacw_readback.sv
module dacw_readback #(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] rd_q;
  logic              rd_ok_q;

  // storage array without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      rd_ok_q <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      rd_ok_q <= (raddr < ADDR_W'(DEPTH)) && vld[raddr];
    end
  end

  assign rdata = rd_ok_q ? rd_q : '0;

  p_write_range_r8: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < ADDR_W'(DEPTH)));
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
  import dacw_pkg::*;
#(
  parameter int NUM_CHIPS   = 3,
  parameter int CH_PER_CHIP = 8,
  parameter int DIV_W       = 8,
  parameter int REQ_VAL_W   = 16,
  localparam int NUM_IDX    = NUM_CHIPS * CH_PER_CHIP,
  localparam int IDX_W      = $clog2(NUM_IDX),
  localparam int CHAIN_W    = NUM_CHIPS * FRAME_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_pdown,
  input  logic [IDX_W-1:0]     req_index,
  input  logic [REQ_VAL_W-1:0] req_value,
  input  logic [DIV_W-1:0]     phase_div,
  input  logic [IDX_W-1:0]     rd_index,
  output logic [VAL_W:0]       rd_data,
  output logic                 busy,
  output logic                 done,
  output logic                 reject,
  output logic                 dac_sdi,
  output logic                 dac_sclk,
  output logic                 dac_cs_n
);
  logic               legal, accept;
  logic [IDX_W-1:0]   idx_q;
  logic [VAL_W-1:0]   val_q;
  logic               pd_q;
  logic [DIV_W-1:0]   div_q;
  logic [CHAIN_W-1:0] chain;
  logic               phase_end;
  logic [VAL_W:0]     wdata;

  assign legal  = (req_index < IDX_W'(NUM_IDX)) &&
                  (req_pdown || (req_value <= REQ_VAL_W'(MAX_VAL)));
  assign accept = req_valid && !busy && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      val_q  <= '0;
      pd_q   <= 1'b0;
      div_q  <= DIV_W'(1);
      reject <= 1'b0;
    end else begin
      reject <= req_valid && !busy && !legal;
      if (accept) begin
        idx_q <= req_index;
        val_q <= req_pdown ? '0 : req_value[VAL_W-1:0];
        pd_q  <= req_pdown;
        div_q <= phase_div;
      end
    end
  end

  dacw_chain_builder #(
    .NUM_CHIPS   (NUM_CHIPS),
    .CH_PER_CHIP (CH_PER_CHIP)
  ) i_builder (
    .idx   (req_index),
    .val   (req_value[VAL_W-1:0]),
    .pdown (req_pdown),
    .chain (chain)
  );

  dacw_phase_timer #(.DIV_W(DIV_W)) i_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .limit     (div_q),
    .phase_end (phase_end)
  );

  dacw_serializer #(.CHAIN_W(CHAIN_W)) i_ser (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .chain     (chain),
    .phase_end (phase_end),
    .busy      (busy),
    .sdi       (dac_sdi),
    .sclk      (dac_sclk),
    .cs_n      (dac_cs_n),
    .finished  (done)
  );

  assign wdata = {pd_q, val_q};

  dacw_readback #(
    .DEPTH  (NUM_IDX),
    .ADDR_W (IDX_W),
    .DATA_W (VAL_W + 1)
  ) i_rb (
    .clk   (clk),
    .rst   (rst),
    .we    (done),
    .waddr (idx_q),
    .wdata (wdata),
    .raddr (rd_index),
    .rdata (rd_data)
  );

  p_no_clash_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && reject));
  p_reject_idle_r7: assert property (@(posedge clk) disable iff (rst)
    reject |-> (!busy && dac_cs_n));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> !reject);
endmodule

// File: tb/test_dac_chain_loader.sv
module test_dac_chain_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_pdown = 1'b0;
  logic [4:0]  req_index = '0;
  logic [15:0] req_value = '0;
  logic [7:0]  phase_div = 8'd1;
  logic [4:0]  rd_index = '0;
  logic [12:0] rd_data;
  logic        busy, done, reject, dac_sdi, dac_sclk, dac_cs_n;

  always #2 clk = ~clk;

  dac_chain_loader i_dac_chain_loader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pdown(req_pdown),
    .req_index(req_index), .req_value(req_value), .phase_div(phase_div),
    .rd_index(rd_index), .rd_data(rd_data), .busy(busy), .done(done),
    .reject(reject), .dac_sdi(dac_sdi), .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [95:0] cap;
  int edges = 0, cs_falls = 0, bad_frame = 0, bad_data = 0;

  // serial line monitors
  always @(posedge dac_sclk) if (dac_cs_n === 1'b0) begin
    cap = {cap[94:0], dac_sdi};
    edges++;
  end
  always @(negedge dac_cs_n) if (rst === 1'b0) begin
    cs_falls++;
    if (dac_sclk !== 1'b1 || dac_sdi !== 1'b1) bad_frame++;
  end
  always @(posedge dac_cs_n) if (rst === 1'b0 && dac_sclk !== 1'b0) bad_frame++;
  always @(dac_sdi) if (dac_cs_n === 1'b0 && dac_sclk === 1'b1) bad_data++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_chain(input bit pd, input int idx, input int val);
    logic [95:0] w;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] f;
      if (k == 2 - idx / 8)
        f = {pd ? 4'h4 : 4'h3, 8'h00, 4'(idx % 8), pd ? 12'h000 : 12'(val), 4'h0};
      else
        f = 32'hF000_0000;
      w[95-32*k -: 32] = f;
    end
    return w;
  endfunction

  task automatic read_idx(input int idx, output logic [12:0] d);
    @(negedge clk); rd_index = 5'(idx);
    @(negedge clk); d = rd_data;
  endtask

  // issue one request and wait for its completion; optionally intrude while busy
  task automatic run_req(input bit pd, input int idx, input int val, input bit intrude,
                         output int blen, output int dcnt);
    cap = '0; edges = 0;
    @(negedge clk);
    req_valid = 1'b1; req_pdown = pd; req_index = 5'(idx); req_value = 16'(val);
    @(negedge clk);
    if (intrude) begin
      req_pdown = 1'b0; req_index = 5'd2; req_value = 16'd200;
    end else req_valid = 1'b0;
    blen = 0; dcnt = 0;
    for (int i = 0; i < 5000; i++) begin
      if (busy) blen++;
      if (reject) check(1'b0, "R10", "reject while busy", 96'(reject), 96'd0);
      if (done) begin
        dcnt++;
        @(negedge clk);
        if (done) dcnt++;
        break;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  localparam logic [21:0] VEC [6] = '{
    {1'b0, 5'd0,  16'd1234},
    {1'b0, 5'd7,  16'd4095},
    {1'b0, 5'd8,  16'd0},
    {1'b0, 5'd15, 16'd2048},
    {1'b0, 5'd23, 16'd1},
    {1'b1, 5'd17, 16'd0}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int blen, dcnt, falls0;
    logic [12:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({dac_cs_n, dac_sclk, dac_sdi} === 3'b111, "R1", "idle lines", 96'({dac_cs_n, dac_sclk, dac_sdi}), 96'd7);
    check({busy, done, reject} === 3'b000, "R1", "status after reset", 96'({busy, done, reject}), 96'd0);
    read_idx(3, d);
    check(d === 13'h0, "R8", "unwritten readback", 96'(d), 96'd0);

    // table walk: R2 R3 R4 R5 R8 R9 R11
    foreach (VEC[i]) begin
      bit pd; int idx, val;
      pd = VEC[i][21]; idx = int'(VEC[i][20:16]); val = int'(VEC[i][15:0]);
      run_req(pd, idx, val, 1'b0, blen, dcnt);
      check(cap === exp_chain(pd, idx, val), pd ? "R3" : "R2", "shifted chain", cap, exp_chain(pd, idx, val));
      check(edges == 96, "R4", "rising edges", 96'(edges), 96'd96);
      check(blen == 292, "R5", "busy length", 96'(blen), 96'd292);
      check(dcnt == 1, "R11", "done pulse width", 96'(dcnt), 96'd1);
      check({dac_cs_n, dac_sclk, dac_sdi} === 3'b111, "R1", "lines high after run", 96'({dac_cs_n, dac_sclk, dac_sdi}), 96'd7);
      read_idx(idx, d);
      check(d === (pd ? 13'h1000 : 13'(val)), pd ? "R9" : "R8", "readback", 96'(d), pd ? 96'h1000 : 96'(val));
    end

    // R7 rejection of out-of-range value and index
    falls0 = cs_falls;
    @(negedge clk); req_valid = 1'b1; req_pdown = 1'b0; req_index = 5'd0; req_value = 16'd4096;
    @(negedge clk); req_valid = 1'b0;
    check(reject === 1'b1 && busy === 1'b0, "R7", "reject on value 4096", 96'({reject, busy}), 96'h2);
    @(negedge clk);
    check(reject === 1'b0, "R7", "reject one cycle", 96'(reject), 96'd0);
    @(negedge clk); req_valid = 1'b1; req_index = 5'd24; req_value = 16'd5;
    @(negedge clk); req_valid = 1'b0;
    check(reject === 1'b1, "R7", "reject on index 24", 96'(reject), 96'd1);
    repeat (5) @(negedge clk);
    check(cs_falls == falls0, "R7", "no chip select after reject", 96'(cs_falls), 96'(falls0));
    read_idx(0, d);
    check(d === 13'd1234, "R7", "readback unchanged", 96'(d), 96'd1234);
    read_idx(24, d);
    check(d === 13'h0, "R8", "out of range readback", 96'(d), 96'd0);

    // R5 divider 3 and divider 0
    phase_div = 8'd3;
    run_req(1'b0, 12, 16'h555, 1'b0, blen, dcnt);
    check(blen == 876, "R5", "busy length with divider 3", 96'(blen), 96'd876);
    check(cap === exp_chain(0, 12, 16'h555), "R4", "chain with divider 3", cap, exp_chain(0, 12, 16'h555));
    phase_div = 8'd0;
    run_req(1'b0, 20, 77, 1'b0, blen, dcnt);
    check(blen == 292, "R5", "divider 0 acts as 1", 96'(blen), 96'd292);

    // R10 request during busy ignored
    phase_div = 8'd1;
    falls0 = cs_falls;
    run_req(1'b0, 1, 100, 1'b1, blen, dcnt);
    repeat (4) @(negedge clk);
    check(cs_falls == falls0 + 1, "R10", "one chip-select window", 96'(cs_falls), 96'(falls0 + 1));
    read_idx(2, d);
    check(d === 13'h0, "R10", "intruder index unwritten", 96'(d), 96'd0);
    read_idx(1, d);
    check(d === 13'd100, "R10", "first request stored", 96'(d), 96'd100);

    // R9 power-down overwrites a value and ignores an illegal value field
    run_req(1'b1, 7, 5000, 1'b0, blen, dcnt);
    check(cap === exp_chain(1, 7, 0), "R9", "power-down chain", cap, exp_chain(1, 7, 0));
    read_idx(7, d);
    check(d === 13'h1000, "R9", "power-down marker", 96'(d), 96'h1000);

    // R5 R6 serial line rules across all runs
    check(bad_frame == 0, "R6", "chip-select framing", 96'(bad_frame), 96'd0);
    check(bad_data == 0, "R5", "data change with clock high", 96'(bad_data), 96'd0);
    finish_run();
  end
endmodule